// File: doc/BRIEF.md
# False Carrier Event Counter

This block keeps a tally of bad carrier starts on a 100 Mb/s receive path. A bad carrier start is a carrier start whose opening start-of-stream delimiter pair did not decode correctly. Other logic reports each carrier start with a one-cycle strobe and a flag saying whether the delimiter pair was good. The block counts the bad ones, but only while the speed-mode input selects 100 Mb/s. It also records any link-disconnect pulse in a sticky flag.

A management engine reads the tally through a simple read strobe and a 5-bit register address. A read of the counter register returns the count and the disconnect flag together, and then clears both. Anything that arrives in the same cycle as that read is kept for the following read, so no event is lost.

Serial management framing, symbol decoding and carrier detection all live outside this block. It only observes the strobes that other logic produces.

Top module: `false_carrier_counter`

## Requirements
- R1: In a cycle where `fast_mode`=1, `carrier_start`=1 and `delim_ok`=0, the count goes up by one. A carrier start with `delim_ok`=1 does not change the count.
- R2: While `fast_mode`=0, carrier starts never change the count, whatever the value of `delim_ok`.
- R3: The 8-bit count stops at 255 and does not wrap to 0.
- R4: When `rd_en`=1 and `rd_addr`=27, `rd_data` on the next cycle shows the state before that read: the count in bits 7:0, the disconnect flag in bit 15, and zeros in bits 14:8. `rd_data` keeps its value until the next cycle with `rd_en`=1.
- R5: A read of address 27 clears the count. If a false event arrives in the same cycle as the read, the count becomes 1 instead.
- R6: A one-cycle `link_drop` pulse sets the disconnect flag. The flag stays set until address 27 is read.
- R7: A read of address 27 clears the disconnect flag. If `link_drop` arrives in the same cycle as the read, the flag stays 1 for the next read.
- R8: A read with `rd_en`=1 and any address other than 27 makes `rd_data` zero on the next cycle. It leaves the count and the flag unchanged.
- R9: Synchronous active-high `rst` clears the count, the flag and `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| carrier_start | input | 1 | One-cycle strobe at the start of each carrier event |
| delim_ok | input | 1 | Delimiter pair decoded correctly; qualifies `carrier_start` |
| fast_mode | input | 1 | 1 = 100 Mb/s mode, 0 = 10 Mb/s mode |
| link_drop | input | 1 | One-cycle link-disconnect pulse |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 5 | Register address for the read |
| rd_data | output | 16 | Registered read value |

## Verification
A corrupted count or flag stays hidden until the next read of address 27. That read returns the wrong word one cycle after its strobe. A bad clear-on-read shows up one read later as a leftover count or a stuck bit 15.

Because of this, the bench reads back after every directed pattern. It also reads about one cycle in ten during a long random phase. Saturation and the same-cycle read collisions each get their own directed cases.

// File: rtl/ffc_pkg.sv
package ffc_pkg;
  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_HIT   = 2'd1,
    RD_OTHER = 2'd2
  } rd_kind_t;

  function automatic logic [15:0] pack_word(input logic [7:0] cnt, input logic flag);
    logic [15:0] w;
    w = '0;
    w[7:0] = cnt;
    w[15] = flag;
    return w;
  endfunction
endpackage

// File: rtl/ffc_event_qual.sv
module ffc_event_qual (
  input  logic carrier_start,
  input  logic delim_ok,
  input  logic fast_mode,
  output logic false_evt
);
  // Only a badly delimited carrier start in fast mode counts.
  always_comb begin
    false_evt = carrier_start & ~delim_ok & fast_mode;
  end
endmodule

// File: rtl/ffc_sat_counter.sv
module ffc_sat_counter #(
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inc,
  input  logic               clr,
  output logic [COUNT_W-1:0] cnt
);
  localparam logic [COUNT_W-1:0] CNT_MAX = {COUNT_W{1'b1}};

  logic [COUNT_W-1:0] cnt_d;

  always_comb begin
    if (clr) begin
      // An event that coincides with the clear starts the next tally.
      cnt_d = inc ? COUNT_W'(1) : '0;
    end else if (inc && (cnt != CNT_MAX)) begin
      cnt_d = cnt + COUNT_W'(1);
    end else begin
      cnt_d = cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_d;
  end
endmodule

// File: rtl/ffc_sticky_flag.sv
module ffc_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (clr) flag <= set;
    else          flag <= flag | set;
  end
endmodule

// File: rtl/ffc_read_port.sv
module ffc_read_port #(
  parameter int ADDR_W   = 5,
  parameter int REG_W    = 16,
  parameter int COUNT_W  = 8,
  parameter int FLAG_POS = 15,
  parameter int REG_ADDR = 27
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic [COUNT_W-1:0] cnt,
  input  logic               flag,
  output logic               hit,
  output logic [REG_W-1:0]   rd_data
);
  import ffc_pkg::*;

  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

  rd_kind_t         kind;
  logic [REG_W-1:0] word;

  always_comb begin
    if (!rd_en)                 kind = RD_IDLE;
    else if (rd_addr == MY_ADDR) kind = RD_HIT;
    else                        kind = RD_OTHER;
  end

  always_comb begin
    word = '0;
    word[COUNT_W-1:0] = cnt;
    word[FLAG_POS] = flag;
  end

  assign hit = (kind == RD_HIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (kind)
        RD_HIT:   rd_data <= word;
        RD_OTHER: rd_data <= '0;
        default:  rd_data <= rd_data;
      endcase
    end
  end
endmodule

// File: rtl/false_carrier_counter.sv
module false_carrier_counter #(
  parameter int ADDR_W   = 5,
  parameter int REG_W    = 16,
  parameter int COUNT_W  = 8,
  parameter int FLAG_POS = 15,
  parameter int REG_ADDR = 27
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              carrier_start,
  input  logic              delim_ok,
  input  logic              fast_mode,
  input  logic              link_drop,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data
);
  logic               false_evt;
  logic               hit;
  logic [COUNT_W-1:0] cnt_q;
  logic               flag_q;

  ffc_event_qual u_qual (
    .carrier_start (carrier_start),
    .delim_ok      (delim_ok),
    .fast_mode     (fast_mode),
    .false_evt     (false_evt)
  );

  ffc_sat_counter #(.COUNT_W(COUNT_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .inc (false_evt),
    .clr (hit),
    .cnt (cnt_q)
  );

  ffc_sticky_flag u_flag (
    .clk  (clk),
    .rst  (rst),
    .set  (link_drop),
    .clr  (hit),
    .flag (flag_q)
  );

  ffc_read_port #(
    .ADDR_W   (ADDR_W),
    .REG_W    (REG_W),
    .COUNT_W  (COUNT_W),
    .FLAG_POS (FLAG_POS),
    .REG_ADDR (REG_ADDR)
  ) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .cnt     (cnt_q),
    .flag    (flag_q),
    .hit     (hit),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/ffc_checker.sv
module ffc_checker #(
  parameter int ADDR_W   = 5,
  parameter int REG_W    = 16,
  parameter int COUNT_W  = 8,
  parameter int FLAG_POS = 15,
  parameter int REG_ADDR = 27
) (
  input logic               clk,
  input logic               rst,
  input logic               carrier_start,
  input logic               delim_ok,
  input logic               fast_mode,
  input logic               link_drop,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  rd_addr,
  input logic [REG_W-1:0]   rd_data,
  input logic [COUNT_W-1:0] cnt_q,
  input logic               flag_q
);
  localparam logic [COUNT_W-1:0] CMAX = {COUNT_W{1'b1}};

  logic rd_hit;
  logic rd_miss;
  assign rd_hit  = rd_en && (rd_addr == ADDR_W'(REG_ADDR));
  assign rd_miss = rd_en && (rd_addr != ADDR_W'(REG_ADDR));

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (fast_mode && carrier_start && !delim_ok && !rd_hit && cnt_q != CMAX) |=> (cnt_q == $past(cnt_q) + COUNT_W'(1))); // R1
  AST_SLOW_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!fast_mode && !rd_hit) |=> $stable(cnt_q)); // R2
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CMAX && !rd_hit) |=> (cnt_q == CMAX)); // R3
  AST_READ_WORD: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> (rd_data[COUNT_W-1:0] == $past(cnt_q) && rd_data[FLAG_POS] == $past(flag_q))); // R4
  AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_data[FLAG_POS-1:COUNT_W] == '0); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && !(fast_mode && carrier_start && !delim_ok)) |=> (cnt_q == '0)); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !rd_hit) |=> flag_q); // R6
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && link_drop) |=> flag_q); // R7
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_miss |=> (rd_data == '0)); // R8
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (cnt_q == '0 && !flag_q && rd_data == '0)); // R9
endmodule

bind false_carrier_counter ffc_checker #(
  .ADDR_W   (ADDR_W),
  .REG_W    (REG_W),
  .COUNT_W  (COUNT_W),
  .FLAG_POS (FLAG_POS),
  .REG_ADDR (REG_ADDR)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .carrier_start (carrier_start),
  .delim_ok      (delim_ok),
  .fast_mode     (fast_mode),
  .link_drop     (link_drop),
  .rd_en         (rd_en),
  .rd_addr       (rd_addr),
  .rd_data       (rd_data),
  .cnt_q         (cnt_q),
  .flag_q        (flag_q)
);

// File: tb/sim_false_carrier_counter.sv
module sim_false_carrier_counter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        carrier_start = 1'b0;
  logic        delim_ok = 1'b1;
  logic        fast_mode = 1'b1;
  logic        link_drop = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  rd_addr = 5'd0;
  logic [15:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Bench model of the requirements
  int unsigned m_cnt = 0;
  bit          m_flag = 1'b0;
  logic [15:0] m_rd = 16'h0;

  always #2 clk = ~clk;

  false_carrier_counter u0 (
    .clk (clk), .rst (rst), .carrier_start (carrier_start), .delim_ok (delim_ok),
    .fast_mode (fast_mode), .link_drop (link_drop), .rd_en (rd_en),
    .rd_addr (rd_addr), .rd_data (rd_data)
  );

  function automatic logic [15:0] expect_word(int unsigned c, bit f);
    return {f, 7'b0, 8'(c)};
  endfunction

  function automatic int unsigned next_cnt(int unsigned c, bit ev, bit rdhit);
    if (rdhit) return ev ? 1 : 0;
    if (ev && c < 255) return c + 1;
    return c;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rd_data=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock with the given inputs; checks rd_data after any read.
  task automatic step(bit cs, bit dok, bit fm, bit ld, bit re, logic [4:0] ad, string req);
    bit ev, rh;
    carrier_start = cs; delim_ok = dok; fast_mode = fm;
    link_drop = ld; rd_en = re; rd_addr = ad;
    @(posedge clk);
    ev = cs && !dok && fm;
    rh = re && (ad == 5'd27);
    if (re) m_rd = rh ? expect_word(m_cnt, m_flag) : 16'h0;
    m_cnt = next_cnt(m_cnt, ev, rh);
    m_flag = rh ? ld : (m_flag | ld);
    #1;
    if (re) check(req, rd_data, m_rd);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(0, 1, 1, 0, 0, 5'd0, "R9");
    step(0, 1, 1, 0, 0, 5'd0, "R9");
    m_cnt = 0; m_flag = 0; m_rd = 16'h0;
    rst = 1'b0;
    check("R9", rd_data, 16'h0000);
  endtask

  task automatic rd27(string req);
    step(0, 1, 1, 0, 1, 5'd27, req);
  endtask

  initial begin
    void'($urandom(32'h5EED_0183));
    do_reset();

    // R1: bad and good delimiters
    repeat (3) step(1, 0, 1, 0, 0, 5'd0, "R1");
    repeat (2) step(1, 1, 1, 0, 0, 5'd0, "R1");
    rd27("R1");
    check("R1", rd_data, 16'h0003);

    // R2: slow mode ignored
    repeat (4) step(1, 0, 0, 0, 0, 5'd0, "R2");
    rd27("R2");
    check("R2", rd_data, 16'h0000);

    // R3: saturation
    repeat (300) step(1, 0, 1, 0, 0, 5'd0, "R3");
    rd27("R3");
    check("R3", rd_data, 16'h00FF);
    rd27("R5");
    check("R5", rd_data, 16'h0000);

    // R5: event in the read cycle is kept
    step(1, 0, 1, 0, 0, 5'd0, "R5");
    step(1, 0, 1, 0, 1, 5'd27, "R5");
    rd27("R5");
    check("R5", rd_data, 16'h0001);

    // R6/R7: sticky flag and collision with read
    step(0, 1, 1, 1, 0, 5'd0, "R6");
    repeat (3) step(0, 1, 1, 0, 0, 5'd0, "R6");
    rd27("R6");
    check("R6", rd_data, 16'h8000);
    step(0, 1, 1, 1, 0, 5'd0, "R7");
    step(0, 1, 1, 1, 1, 5'd27, "R7");
    rd27("R7");
    check("R7", rd_data, 16'h8000);
    rd27("R7");
    check("R7", rd_data, 16'h0000);

    // R8: other address reads zero and clears nothing
    step(1, 0, 1, 1, 0, 5'd0, "R8");
    step(0, 1, 1, 0, 1, 5'd26, "R8");
    check("R8", rd_data, 16'h0000);
    step(0, 1, 1, 0, 0, 5'd0, "R4");
    check("R4", rd_data, 16'h0000);
    rd27("R8");
    check("R8", rd_data, 16'h8001);

    // R9: reset mid-count
    repeat (5) step(1, 0, 1, 1, 0, 5'd0, "R9");
    do_reset();
    rd27("R9");
    check("R9", rd_data, 16'h0000);

    // Random phase: R4 read word versus model
    for (int i = 0; i < 4000; i++) begin
      bit re;
      logic [4:0] ad;
      re = ($urandom % 10) == 0;
      ad = (($urandom % 4) == 0) ? 5'($urandom) : 5'd27;
      step(1'($urandom), 1'($urandom), ($urandom % 4) != 0, ($urandom % 40) == 0, re, ad, "R4");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule